// File: doc/BRIEF.md
# Variable-length operand specifier decoder

This block parses one operand specifier from an instruction byte stream. Bytes arrive one at a time on a valid/ready handshake. The first byte is classified as soon as it is taken. Its top two bits can mark a six-bit short literal. Otherwise its upper nibble is an addressing mode and its lower nibble a general register number. From that class the decoder knows how many more bytes belong to the specifier. It then collects a little-endian displacement of one, two or four bytes, or, for the index prefix, parses exactly one nested base specifier.

When the last byte of the specifier has been taken, the decoder raises a one-cycle done strobe. With it come the decoded mode, base register, index register with its valid flag, the displacement (sign-extended) or the literal (zero-extended), the total byte count, and an error flag for an illegal base after an index prefix. A downstream address stage consumes these results. Effective-address arithmetic, memory and register reads, and immediates that depend on the data type are left to other blocks.

Top module: `spec_operand_dec`

## Requirements
- R1: For a first byte whose bits [7:6] are not 00 and whose upper nibble is not 4, mode_o reports bits [7:4] and base_reg_o reports bits [3:0].
- R2: A first byte with bits [7:6] = 00 is a complete short literal. It gives mode_o = 0, base_reg_o = 0, disp_o = the zero-extended bits [5:0], length_o = 1 and err_o = 0.
- R3: Modes 5 through 9 take no extension bytes. They end the parse after the first byte with disp_o = 0 and length_o = 1.
- R4: Modes A and B take one displacement byte, C and D take two, and E and F take four. Bytes arrive least significant first, disp_o is their value sign-extended to 32 bits, and length_o is 2, 3 or 5.
- R5: Upper nibble 4 is the index prefix. Its lower nibble appears on index_reg_o with index_vld_o = 1, the next bytes form a full base specifier decoded by R1, R3 and R4, and length_o is 1 plus the length of the base.
- R6: A base byte after an index prefix that is itself a short literal or another index prefix ends the parse. It gives err_o = 1, length_o = 2, mode_o = 0, base_reg_o = 0 and disp_o = 0, and index_reg_o keeps the prefix register.
- R7: done_o is high for exactly one cycle, the cycle after the clock edge that takes the final byte. ready_o is low in that cycle and high in every other cycle after reset.
- R8: While rst_ni is low, the decoder returns to waiting for a first byte, with ready_o = 1, done_o = 0 and every result output zero.
- R9: Cycles with valid_i low consume no byte and do not advance the parse, whatever byte_i carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | byte_i holds a stream byte |
| byte_i | input | 8 | Instruction stream byte |
| ready_o | output | 1 | Decoder can take a byte this cycle |
| done_o | output | 1 | One-cycle strobe: results valid |
| mode_o | output | 4 | Addressing mode of the base specifier (0 for a literal) |
| base_reg_o | output | 4 | Base register number |
| index_reg_o | output | 4 | Index register number |
| index_vld_o | output | 1 | Specifier carried an index prefix |
| disp_o | output | 32 | Sign-extended displacement or zero-extended literal |
| length_o | output | 3 | Total specifier length in bytes |
| err_o | output | 1 | Illegal base after index prefix |

## Verification
Each result is due exactly one cycle after the rising edge that takes the last byte of a specifier. ready_o returns high one cycle later still. The bench drives every byte on a falling edge and samples on the next falling edge. It expects done_o low after every non-final byte and high, with all fields correct and ready_o low, after the final one. One cycle after that it expects done_o low and ready_o high again. Random idle gaps with junk on byte_i are inserted before bytes, and done_o is checked to stay low through them.

// File: rtl/spec_dec_pkg.sv
package spec_dec_pkg;
  localparam int BYTE_W  = 8;
  localparam int NIB_W   = 4;
  localparam int EXT_MAX = 4;
  localparam int DISP_W  = EXT_MAX * BYTE_W;
  localparam int EXT_W   = $clog2(EXT_MAX + 1);
  localparam int LEN_W   = 3;

  localparam logic [NIB_W-1:0] MODE_INDEX = 4'h4;

  typedef enum logic [1:0] {
    ST_FIRST,
    ST_BASE,
    ST_EXT,
    ST_DONE
  } dec_st_e;

  typedef struct packed {
    logic             lit;
    logic             idx;
    logic [EXT_W-1:0] ext_n;
  } spec_cls_t;
endpackage

// File: rtl/spec_classify.sv
module spec_classify
  import spec_dec_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output spec_cls_t         cls_o
);
  logic [NIB_W-1:0] mode;
  assign mode = byte_i[BYTE_W-1 -: NIB_W];

  always_comb begin
    cls_o.lit   = (byte_i[BYTE_W-1 -: 2] == 2'b00);
    cls_o.idx   = (mode == MODE_INDEX);
    cls_o.ext_n = '0;
    unique case (mode)
      4'hA, 4'hB: cls_o.ext_n = EXT_W'(1);
      4'hC, 4'hD: cls_o.ext_n = EXT_W'(2);
      4'hE, 4'hF: cls_o.ext_n = EXT_W'(4);
      default:    cls_o.ext_n = '0;
    endcase
  end
endmodule

// File: rtl/spec_disp_acc.sv
module spec_disp_acc #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      wr_i,
  input  logic [SEL_W-1:0]          lane_i,
  input  logic [LANE_W-1:0]         data_i,
  input  logic [SEL_W-1:0]          width_i,
  output logic [LANES*LANE_W-1:0]   value_o
);
  localparam int ACC_W = LANES * LANE_W;
  localparam int SEL_W = $clog2(LANES + 1);

  logic [ACC_W-1:0] raw;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              lane_q <= '0;
      else if (wr_i && lane_i == SEL_W'(g))     lane_q <= data_i;
      else if (clr_i)                           lane_q <= '0;
    end
    assign raw[g*LANE_W +: LANE_W] = lane_q;
  end

  // upper lanes are cleared, so extension only needs to OR in ones
  always_comb begin
    value_o = raw;
    for (int w = 1; w < LANES; w++) begin
      if (width_i == SEL_W'(w) && raw[w*LANE_W-1])
        value_o = raw | ({ACC_W{1'b1}} << (w*LANE_W));
    end
  end
endmodule

// File: rtl/spec_operand_dec.sv
module spec_operand_dec
  import spec_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [NIB_W-1:0]  mode_o,
  output logic [NIB_W-1:0]  base_reg_o,
  output logic [NIB_W-1:0]  index_reg_o,
  output logic              index_vld_o,
  output logic [DISP_W-1:0] disp_o,
  output logic [LEN_W-1:0]  length_o,
  output logic              err_o
);
  dec_st_e          st_q;
  spec_cls_t        cls;
  logic             take;
  logic [NIB_W-1:0] mode_q, base_q, idx_q;
  logic             idxv_q, err_q;
  logic [LEN_W-1:0] len_q;
  logic [EXT_W-1:0] need_q, cnt_q;

  logic              acc_clr, acc_wr;
  logic [EXT_W-1:0]  acc_lane;
  logic [BYTE_W-1:0] acc_data;

  spec_classify u_cls (
    .byte_i (byte_i),
    .cls_o  (cls)
  );

  assign ready_o = (st_q != ST_DONE);
  assign take    = valid_i && ready_o;

  assign acc_clr  = take && (st_q == ST_FIRST);
  assign acc_wr   = take && ((st_q == ST_EXT) || (st_q == ST_FIRST && cls.lit));
  assign acc_lane = (st_q == ST_EXT) ? cnt_q : '0;
  assign acc_data = cls.lit && (st_q == ST_FIRST) ? {2'b00, byte_i[BYTE_W-3:0]} : byte_i;

  spec_disp_acc #(
    .LANES  (EXT_MAX),
    .LANE_W (BYTE_W)
  ) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (acc_clr),
    .wr_i    (acc_wr),
    .lane_i  (acc_lane),
    .data_i  (acc_data),
    .width_i (need_q),
    .value_o (disp_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_FIRST;
      mode_q <= '0;
      base_q <= '0;
      idx_q  <= '0;
      idxv_q <= 1'b0;
      err_q  <= 1'b0;
      len_q  <= '0;
      need_q <= '0;
      cnt_q  <= '0;
    end else begin
      unique case (st_q)
        ST_FIRST: if (take) begin
          err_q  <= 1'b0;
          idxv_q <= 1'b0;
          idx_q  <= '0;
          len_q  <= LEN_W'(1);
          cnt_q  <= '0;
          if (cls.lit) begin
            mode_q <= '0;
            base_q <= '0;
            need_q <= '0;
            st_q   <= ST_DONE;
          end else if (cls.idx) begin
            idxv_q <= 1'b1;
            idx_q  <= byte_i[NIB_W-1:0];
            mode_q <= '0;
            base_q <= '0;
            need_q <= '0;
            st_q   <= ST_BASE;
          end else begin
            mode_q <= byte_i[BYTE_W-1 -: NIB_W];
            base_q <= byte_i[NIB_W-1:0];
            need_q <= cls.ext_n;
            st_q   <= (cls.ext_n == '0) ? ST_DONE : ST_EXT;
          end
        end
        ST_BASE: if (take) begin
          len_q <= len_q + LEN_W'(1);
          if (cls.lit || cls.idx) begin
            err_q <= 1'b1;
            st_q  <= ST_DONE;
          end else begin
            mode_q <= byte_i[BYTE_W-1 -: NIB_W];
            base_q <= byte_i[NIB_W-1:0];
            need_q <= cls.ext_n;
            st_q   <= (cls.ext_n == '0) ? ST_DONE : ST_EXT;
          end
        end
        ST_EXT: if (take) begin
          len_q <= len_q + LEN_W'(1);
          cnt_q <= cnt_q + EXT_W'(1);
          if (cnt_q + EXT_W'(1) == need_q) st_q <= ST_DONE;
        end
        ST_DONE: st_q <= ST_FIRST;
        default: st_q <= ST_FIRST;
      endcase
    end
  end

  assign done_o      = (st_q == ST_DONE);
  assign mode_o      = mode_q;
  assign base_reg_o  = base_q;
  assign index_reg_o = idx_q;
  assign index_vld_o = idxv_q;
  assign length_o    = len_q;
  assign err_o       = err_q;
endmodule

// File: rtl/spec_dec_chk.sv
module spec_dec_chk
  import spec_dec_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [BYTE_W-1:0] byte_i,
  input logic              ready_o,
  input logic              done_o,
  input logic [NIB_W-1:0]  mode_o,
  input logic [NIB_W-1:0]  base_reg_o,
  input logic [NIB_W-1:0]  index_reg_o,
  input logic              index_vld_o,
  input logic [DISP_W-1:0] disp_o,
  input logic [LEN_W-1:0]  length_o,
  input logic              err_o
);
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ready_o); // R7
  AST_READY_ELSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ready_o); // R7
  AST_LIT_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o && mode_o == 4'h0) |->
      (length_o == 3'd1 && !index_vld_o && disp_o[DISP_W-1:6] == '0)); // R2
  AST_REG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o && mode_o >= 4'h5 && mode_o <= 4'h9) |-> (disp_o == '0)); // R3
  AST_BYTE_DISP_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_o[3:1] == 3'b101) |-> (length_o == (index_vld_o ? 3'd3 : 3'd2))); // R4
  AST_IDX_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && index_vld_o) |-> (length_o >= 3'd2)); // R5
  AST_ERR_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (index_vld_o && length_o == 3'd2 && disp_o == '0)); // R6
endmodule

bind spec_operand_dec spec_dec_chk u_chk (.*);

// File: tb/spec_operand_dec_tb_top.sv
`timescale 1ns/1ps
module spec_operand_dec_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        ready_o, done_o, index_vld_o, err_o;
  logic [3:0]  mode_o, base_reg_o, index_reg_o;
  logic [31:0] disp_o;
  logic [2:0]  length_o;

  int total = 0;
  int bad   = 0;
  logic [7:0] tx [6];

  always #4 clk_i = ~clk_i;

  spec_operand_dec dut_i (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(logic [31:0] d, int n);
    case (n)
      1: return {{24{d[7]}}, d[7:0]};
      2: return {{16{d[15]}}, d[15:0]};
      default: return d;
    endcase
  endfunction

  // called on a falling edge with the decoder idle
  task automatic run_spec(int nb, logic [3:0] e_mode, logic [3:0] e_base, logic [3:0] e_idx,
                          logic e_idxv, logic [31:0] e_disp, logic [2:0] e_len, logic e_err,
                          string req);
    for (int i = 0; i < nb; i++) begin
      int gap = $urandom_range(0, 2);
      for (int g = 0; g < gap; g++) begin
        valid_i = 1'b0;
        byte_i  = 8'($urandom);
        @(negedge clk_i);
        chk("R9", "done in stall", 32'(done_o), 32'd0);
      end
      valid_i = 1'b1;
      byte_i  = tx[i];
      chk("R7", "ready while parsing", 32'(ready_o), 32'd1);
      @(negedge clk_i);
      if (i < nb - 1) chk("R7", "early done", 32'(done_o), 32'd0);
    end
    valid_i = 1'b0;
    byte_i  = 8'($urandom);
    chk("R7", "done", 32'(done_o), 32'd1);
    chk("R7", "ready in done", 32'(ready_o), 32'd0);
    chk(req, "mode", 32'(mode_o), 32'(e_mode));
    chk(req, "base", 32'(base_reg_o), 32'(e_base));
    chk(req, "index reg", 32'(index_reg_o), 32'(e_idx));
    chk(req, "index vld", 32'(index_vld_o), 32'(e_idxv));
    chk(req, "disp", disp_o, e_disp);
    chk(req, "length", 32'(length_o), 32'(e_len));
    chk(req, "err", 32'(err_o), 32'(e_err));
    @(negedge clk_i);
    chk("R7", "done pulse end", 32'(done_o), 32'd0);
    chk("R7", "ready back", 32'(ready_o), 32'd1);
  endtask

  task automatic do_lit(logic [5:0] v);
    tx[0] = {2'b00, v};
    run_spec(1, 4'h0, 4'h0, 4'h0, 1'b0, {26'b0, v}, 3'd1, 1'b0, "R2");
  endtask

  // pre: index prefix with register xr; m/r: base mode and register; d: displacement
  task automatic do_base(logic pre, logic [3:0] xr, logic [3:0] m, logic [3:0] r, logic [31:0] d);
    int n = (m >= 4'hE) ? 4 : (m >= 4'hC) ? 2 : (m >= 4'hA) ? 1 : 0;
    int o = pre ? 1 : 0;
    string req = pre ? "R5" : (n == 0) ? "R1,R3" : "R1,R4";
    if (pre) tx[0] = {4'h4, xr};
    tx[o] = {m, r};
    for (int k = 0; k < n; k++) tx[o+1+k] = d[k*8 +: 8];
    run_spec(o + 1 + n, m, r, pre ? xr : 4'h0, pre, (n == 0) ? 32'd0 : sx(d, n),
             3'(o + 1 + n), 1'b0, req);
  endtask

  task automatic do_err(logic [3:0] xr, logic [7:0] b2);
    tx[0] = {4'h4, xr};
    tx[1] = b2;
    run_spec(2, 4'h0, 4'h0, xr, 1'b1, 32'd0, 3'd2, 1'b1, "R6");
  endtask

  task automatic check_idle(string req);
    chk(req, "ready", 32'(ready_o), 32'd1);
    chk(req, "done", 32'(done_o), 32'd0);
    chk(req, "mode", 32'(mode_o), 32'd0);
    chk(req, "disp", disp_o, 32'd0);
    chk(req, "length", 32'(length_o), 32'd0);
    chk(req, "err", 32'(err_o), 32'd0);
    chk(req, "index vld", 32'(index_vld_o), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk_i);
    check_idle("R8");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_idle("R8");

    // directed corners
    do_lit(6'h3F);
    do_lit(6'h00);
    do_base(1'b0, 4'h0, 4'h5, 4'h3, 32'h0);
    do_base(1'b0, 4'h0, 4'h9, 4'hF, 32'h0);
    do_base(1'b0, 4'h0, 4'hA, 4'h2, 32'h0000_0080);
    do_base(1'b0, 4'h0, 4'hB, 4'h1, 32'h0000_007F);
    do_base(1'b0, 4'h0, 4'hC, 4'h4, 32'h0000_7FFF);
    do_base(1'b0, 4'h0, 4'hD, 4'h6, 32'h0000_8001);
    do_base(1'b0, 4'h0, 4'hE, 4'h7, 32'h8000_0000);
    do_base(1'b0, 4'h0, 4'hF, 4'hE, 32'h1234_5678);
    do_base(1'b1, 4'h9, 4'hE, 4'hB, 32'hFEDC_BA98);
    do_base(1'b1, 4'h3, 4'h6, 4'h8, 32'h0);
    do_err(4'hC, 8'h45);
    do_err(4'h1, 8'h2A);

    // reset in the middle of a displacement parse
    valid_i = 1'b1;
    byte_i  = 8'hE3;
    @(negedge clk_i);
    byte_i  = 8'h77;
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni  = 1'b0;
    #1;
    check_idle("R8");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    do_lit(6'h15);

    for (int it = 0; it < 400; it++) begin
      int kind = $urandom_range(0, 4);
      logic [3:0] xr = 4'($urandom);
      logic [3:0] r  = 4'($urandom);
      logic [31:0] d = $urandom;
      case (kind)
        0: do_lit(6'($urandom));
        1: do_base(1'b0, xr, 4'($urandom_range(5, 9)), r, d);
        2: do_base(1'b0, xr, 4'($urandom_range(10, 15)), r, d);
        3: do_base(1'b1, xr, 4'($urandom_range(5, 15)), r, d);
        default: do_err(xr, ($urandom_range(0, 1) != 0) ? {4'h4, r} : {2'b00, 6'($urandom)});
      endcase
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule